// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers interrupt requests from a set of peripheral lines and presents one combined request to a processor core. Each line can work in one of two modes. In level mode the line is sampled once per clock, and its request lasts only as long as the sampled level stays high. In edge mode a rising transition is captured in a per-line latch, and the request stays pending until that line is acknowledged. A mask register removes individual lines from consideration. Among the lines that remain, the lowest-numbered one wins.

When the core raises its acknowledge input, the controller freezes the current winner. It then drives a vector byte onto a data bus. The programmed base supplies the upper bits of that byte and the winning line index supplies the lowest bits. The core multiplies this number by four to locate a table entry. The vector stays constant for the whole acknowledge, so later requests and later configuration writes cannot change it mid-read.

A small register port sets the line modes, the mask and the vector base.

Top module: `pvic_top`

## Requirements
- R1: After reset, `irq_o`, `vec_oe_o` and `vec_o` are low. The mode register reads 0x00 (all lines level). The mask register reads 0xFF (all lines blocked). The base register reads 0x00.
- R2: The register address selects the register: 0 is mode (bit n = 1 puts line n in edge mode), 1 is mask (bit n = 1 blocks line n) and 2 is base (bits 7:3 stored, bits 2:0 read as 0). Address 3 reads 0x00. A write takes effect on the clock edge where `cfg_wr_i` is high.
- R3: An unmasked level-mode line raises `irq_o` at the first clock edge where it is sampled high. It withdraws its request at the first clock edge where it is sampled low.
- R4: An unmasked edge-mode line that sees a rising transition keeps `irq_o` high after the input returns low, until that line is acknowledged.
- R5: The edge latch of the line that wins an acknowledge is cleared. The latches of other pending edge lines are kept and are served by later acknowledges.
- R6: When several unmasked lines are pending, the lowest-numbered line wins.
- R7: A masked line neither raises `irq_o` nor wins arbitration.
- R8: Assume the first clock edge at which `inta_i` is seen high. From the next cycle until the edge after `inta_i` falls, `vec_oe_o` is high and `vec_o` = {base[7:3], winning index}. At all other times `vec_o` is 0x00.
- R9: A new request, or a base write, that arrives during an acknowledge does not change the vector being driven.
- R10: `irq_o` is high exactly when at least one unmasked line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Peripheral request lines |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data for `cfg_addr_i` |
| irq_o | output | 1 | Combined interrupt request to the core |
| inta_i | input | 1 | Interrupt acknowledge from the core |
| vec_oe_o | output | 1 | Vector valid on the data bus |
| vec_o | output | 8 | Vector number |

## Verification
The bench builds the controller with its default parameters: eight lines and an 8-bit vector. This makes a 3-bit line index and a 5-bit base field. With this setting, the lowest and highest line can both be tested as winners. All-masked and all-requesting patterns can be applied. Level and edge lines can be mixed within one pattern. The bench also checks that an edge latch on the line that lost one acknowledge is still served by the next acknowledge.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned CFG_AW = 2;
  localparam logic [CFG_AW-1:0] REG_MODE = 2'd0;
  localparam logic [CFG_AW-1:0] REG_MASK = 2'd1;
  localparam logic [CFG_AW-1:0] REG_BASE = 2'd2;
endpackage

// File: rtl/pvic_line.sv
// One request line: sample register, edge detector and pending latch.
module pvic_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic samp_q, samp_d;
  logic prev_q, prev_d;
  logic hold_q, hold_d;
  logic rise;

  assign rise = samp_q & ~prev_q;

  always_comb begin
    samp_d = req_i;
    prev_d = samp_q;
    if (!edge_mode_i)  hold_d = 1'b0;
    else if (rise)     hold_d = 1'b1;
    else if (clr_i)    hold_d = 1'b0;
    else               hold_d = hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      prev_q <= prev_d;
      hold_q <= hold_d;
    end
  end

  assign pend_o = edge_mode_i ? hold_q : samp_q;
endmodule

// File: rtl/pvic_arb.sv
// Fixed priority: lowest index wins.
module pvic_arb #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned BASE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [VEC_W-1:0]  wdata_i,
  output logic [VEC_W-1:0]  rdata_o,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      mask_o,
  output logic [BASE_W-1:0] base_o
);
  localparam int unsigned LOW_W = VEC_W - BASE_W;

  logic [N-1:0]      mode_q, mode_d, mask_q, mask_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              mode_en, mask_en, base_en;

  assign mode_en = wr_i && (addr_i == REG_MODE);
  assign mask_en = wr_i && (addr_i == REG_MASK);
  assign base_en = wr_i && (addr_i == REG_BASE);

  always_comb begin
    mode_d = mode_en ? wdata_i[N-1:0] : mode_q;
    mask_d = mask_en ? wdata_i[N-1:0] : mask_q;
    base_d = base_en ? wdata_i[VEC_W-1:LOW_W] : base_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= '1;
      base_q <= '0;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_MODE: rdata_o[N-1:0] = mode_q;
      REG_MASK: rdata_o[N-1:0] = mask_q;
      REG_BASE: rdata_o = {base_q, {LOW_W{1'b0}}};
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign base_o = base_q;
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 cfg_wr_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [VEC_W-1:0]     cfg_wdata_i,
  output logic [VEC_W-1:0]     cfg_rdata_o,
  output logic                 irq_o,
  input  logic                 inta_i,
  output logic                 vec_oe_o,
  output logic [VEC_W-1:0]     vec_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_LINES);
  localparam int unsigned BASE_W = VEC_W - IDX_W;

  logic [NUM_LINES-1:0] mode_q, mask_q, pend_raw, pend, clr;
  logic [BASE_W-1:0]    base_q;
  logic                 any_pend;
  logic [IDX_W-1:0]     win_idx;
  logic                 ack_q, ack_d, ack_start;
  logic [VEC_W-1:0]     vec_q, vec_d;

  pvic_regs #(.N(NUM_LINES), .VEC_W(VEC_W), .BASE_W(BASE_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .mode_o(mode_q), .mask_o(mask_q), .base_o(base_q)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    pvic_line u_line (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i[g]),
      .edge_mode_i(mode_q[g]), .clr_i(clr[g]), .pend_o(pend_raw[g])
    );
    assign clr[g] = ack_start && any_pend && (win_idx == IDX_W'(g));
  end

  assign pend = pend_raw & ~mask_q;

  pvic_arb #(.N(NUM_LINES), .IDX_W(IDX_W)) u_arb (
    .pend_i(pend), .any_o(any_pend), .idx_o(win_idx)
  );

  assign ack_start = inta_i & ~ack_q;

  always_comb begin
    ack_d = inta_i;
    vec_d = ack_start ? {base_q, win_idx} : vec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_d;
      vec_q <= vec_d;
    end
  end

  assign irq_o    = any_pend;
  assign vec_oe_o = ack_q;
  assign vec_o    = ack_q ? vec_q : '0;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 inta_i,
  input logic                 irq_o,
  input logic                 vec_oe_o,
  input logic [VEC_W-1:0]     vec_o,
  input logic [NUM_LINES-1:0] mask_q
);
  // R8
  oe_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> $past(inta_i));
  // R8
  ack_drives_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inta_i) |=> vec_oe_o);
  // R8
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_oe_o |-> (vec_o == '0));
  // R9
  vec_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_o));
  // R7
  all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);
endmodule

bind pvic_top pvic_chk #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inta_i(inta_i), .irq_o(irq_o),
  .vec_oe_o(vec_oe_o), .vec_o(vec_o), .mask_q(mask_q)
);

// File: tb/pvic_top_bench.sv
module pvic_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req;
  logic       wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, vec;
  logic       irq, inta, oe;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pvic_top u_pvic_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cfg_wr_i(wr), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .irq_o(irq), .inta_i(inta),
    .vec_oe_o(oe), .vec_o(vec)
  );

  // {base, mode, mask, req, exp_irq, exp_vec}
  localparam logic [47:0] TBL [0:7] = '{
    48'hA8_00_00_01_01_A8,   // R3 R8 line 0 level
    48'h40_00_00_0C_01_42,   // R6
    48'h40_00_04_0C_01_43,   // R7
    48'h10_FF_00_80_01_17,   // R4 edge line 7
    48'hF8_00_FF_FF_00_00,   // R7 all masked
    48'h20_0F_01_31_01_24,   // R7 R6 mixed modes
    48'h80_00_7F_80_01_87,   // R6 line 7 alone
    48'h08_55_00_66_01_09    // R6 R10 mixed
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; req = '0; wr = 1'b0; addr = '0; wdata = '0; inta = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 oe", oe, 0); chk("R1 vec", vec, 0);
    rst_n = 1'b1;
    rd_reg(2'd0, r); chk("R1 mode", r, 8'h00);
    rd_reg(2'd1, r); chk("R1 mask", r, 8'hFF);
    rd_reg(2'd2, r); chk("R1 base", r, 8'h00);
    // R2 register map
    wr_reg(2'd2, 8'hFF); rd_reg(2'd2, r); chk("R2 base low bits", r, 8'hF8);
    wr_reg(2'd0, 8'h5A); rd_reg(2'd0, r); chk("R2 mode", r, 8'h5A);
    rd_reg(2'd3, r); chk("R2 unused addr", r, 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr_reg(2'd0, 8'h00);
      wr_reg(2'd2, TBL[i][47:40]);
      wr_reg(2'd0, TBL[i][39:32]);
      wr_reg(2'd1, TBL[i][31:24]);
      @(negedge clk); req = TBL[i][23:16];
      repeat (3) @(negedge clk);
      chk($sformatf("R10 irq vec%0d", i), irq, TBL[i][8]);
      if (TBL[i][8]) begin
        inta = 1'b1;
        @(negedge clk);
        chk($sformatf("R8 oe vec%0d", i), oe, 1);
        chk($sformatf("R6 vector vec%0d", i), vec, TBL[i][7:0]);
        inta = 1'b0;
        @(negedge clk);
        chk($sformatf("R8 released vec%0d", i), {oe, vec}, 9'h000);
      end
      req = '0;
      repeat (3) @(negedge clk);
    end

    // R3 level follows input
    wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'h00); wr_reg(2'd2, 8'h30);
    @(negedge clk); req = 8'h10;
    @(negedge clk); chk("R3 rise", irq, 1);
    req = 8'h00;
    @(negedge clk); chk("R3 fall", irq, 0);

    // R4 R5 edge pulses on lines 2 and 5
    wr_reg(2'd0, 8'hFF);
    @(negedge clk); req = 8'h24;
    @(negedge clk); req = 8'h00;
    repeat (4) @(negedge clk);
    chk("R4 held after pulse", irq, 1);
    inta = 1'b1; @(negedge clk);
    chk("R5 first vector", vec, 8'h32);
    inta = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 other latch kept", irq, 1);
    inta = 1'b1; @(negedge clk);
    chk("R5 second vector", vec, 8'h35);
    inta = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 all cleared", irq, 0);

    // R9 freeze during acknowledge
    wr_reg(2'd0, 8'h00);
    @(negedge clk); req = 8'h10;
    repeat (2) @(negedge clk);
    inta = 1'b1; @(negedge clk);
    chk("R9 initial", vec, 8'h34);
    req = 8'h12; wr = 1'b1; addr = 2'd2; wdata = 8'hC0;
    @(negedge clk); wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 held vector", vec, 8'h34);
    inta = 1'b0; @(negedge clk);
    inta = 1'b1; @(negedge clk);
    chk("R9 next ack sees new state", vec, 8'hC1);
    inta = 1'b0; req = '0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule